// File: doc/BRIEF.md
# USB Full-Speed Receive Front End

This block turns the two data lines of a full-speed USB link into a stream of received bytes. The system clock runs at eight times the line bit rate. Both lines are assumed to be synchronous to that clock already. A bit timer re-aligns its phase on every D+ transition so that each bit is sampled near the middle of its cell. The sampled levels are NRZI-decoded, and the zero that the transmitter stuffs after six ones is removed. Every eight kept bits are then presented as a byte with a one-cycle strobe.

An end-of-packet indication follows the single-ended-zero line state. A receiving-active flag frames each packet. Any logic that interprets packets (sync, PID, CRC, buffering) sits downstream and watches the byte strobe together with the end-of-packet and active flags.

Top module: `usb_fs_rx`

## Requirements
- R1: While rst_ni is low, rx_valid_o and rx_active_o are 0.
- R2: rx_active_o rises in the cycle after a J-to-K transition (J means D+ high and D− low, K means D+ low and D− high) seen while inactive. It falls in the cycle after SE0 (both lines low) is seen.
- R3: After any D+ transition registered at a clock edge, the line is sampled at the third following edge and then every eight edges, until the next transition.
- R4: A sampled D+ level equal to the previous sample decodes as 1, and a different level decodes as 0. At the start of reception the previous sample is preset to J.
- R5: Kept bits fill the byte LSB first. rx_valid_o pulses for exactly one cycle after the edge that keeps the eighth bit, and rx_byte_o then holds that byte.
- R6: After six consecutive decoded ones, the next sample is discarded and the ones run restarts. A discarded sample is not counted toward the byte.
- R7: eop_o is high in exactly those cycles in which D+ and D− are both low.
- R8: No sample is taken while SE0 is present. The partial byte and the ones run are cleared at SE0, so a byte cut short by the end of a packet never raises rx_valid_o.
- R9: A return from SE0 to J does not start reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, eight times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line level, clock-synchronous |
| dm_i | input | 1 | D− line level, clock-synchronous |
| rx_byte_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe: rx_byte_o is new |
| eop_o | output | 1 | Both lines low (end of packet) |
| rx_active_o | output | 1 | Packet reception in progress |

## Verification
The bench uses the default parameters: eight clocks per bit, a resync delay of three clocks, a stuffing run of six and an eight-bit byte. These settings put bit cells that alternate between nine and seven clocks within reach, so resync after every edge is exercised. They also allow runs of 0xFF that force stuffed bits in the middle of a byte and across byte borders, and a packet cut off five bits into a byte. The behavioural model predicts the strobe, the byte, the end-of-packet flag and the active flag on every clock. Each packet's received bytes are also compared with the bytes that were sent.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  // {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_K   = 2'b01,
    LN_J   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  function automatic line_e line_of(logic dp, logic dm);
    return line_e'({dp, dm});
  endfunction
endpackage

// File: rtl/usbrx_line.sv
module usbrx_line
  import usbrx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  output logic edge_o,
  output logic eop_o,
  output logic start_o,
  output logic active_o
);
  logic  dp_q, active_q;
  line_e line;

  assign line     = line_of(dp_i, dm_i);
  assign edge_o   = dp_i ^ dp_q;
  assign eop_o    = (line == LN_SE0);
  // only J->K while idle opens a packet
  assign start_o  = edge_o && dp_q && (line == LN_K) && !active_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q     <= 1'b1;
      active_q <= 1'b0;
    end else begin
      dp_q <= dp_i;
      if (eop_o)        active_q <= 1'b0;
      else if (start_o) active_q <= 1'b1;
    end
  end

  // R2
  active_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(eop_o));
endmodule

// File: rtl/usbrx_timer.sv
module usbrx_timer #(
  parameter int OVERSAMPLE   = 8,
  parameter int RESYNC_DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic strobe_o
);
  localparam int CNT_W = $clog2(OVERSAMPLE);

  logic [CNT_W-1:0] cnt_q;

  assign strobe_o = (cnt_q == CNT_W'(RESYNC_DELAY - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (edge_i)                          cnt_q <= '0;
    else if (cnt_q == CNT_W'(OVERSAMPLE - 1)) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  // R3
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/usbrx_deser.sv
module usbrx_deser #(
  parameter int DATA_W    = 8,
  parameter int STUFF_LEN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eop_i,
  input  logic              shift_i,
  input  logic              dp_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int ONES_W = $clog2(STUFF_LEN + 1);
  localparam int BIT_W  = $clog2(DATA_W);

  logic              prev_q, valid_q;
  logic [ONES_W-1:0] ones_q;
  logic [BIT_W-1:0]  bits_q;
  logic [DATA_W-1:0] data_q;
  logic              bit_dec, drop;

  assign bit_dec = (dp_i == prev_q);
  assign drop    = (ones_q == ONES_W'(STUFF_LEN));
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      ones_q  <= '0;
      bits_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        prev_q <= 1'b1;  // J
        ones_q <= '0;
        bits_q <= '0;
      end else if (eop_i) begin
        ones_q <= '0;
        bits_q <= '0;
      end else if (shift_i) begin
        prev_q <= dp_i;
        if (drop) begin
          ones_q <= '0;
        end else begin
          ones_q <= bit_dec ? ones_q + 1'b1 : '0;
          data_q <= {bit_dec, data_q[DATA_W-1:1]};
          if (bits_q == BIT_W'(DATA_W - 1)) begin
            bits_q  <= '0;
            valid_q <= 1'b1;
          end else begin
            bits_q <= bits_q + 1'b1;
          end
        end
      end
    end
  end

  // R6
  stuff_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !start_i && !eop_i && drop) |=> ($stable(data_o) && !valid_o));
  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx #(
  parameter int OVERSAMPLE   = 8,
  parameter int RESYNC_DELAY = 3,
  parameter int STUFF_LEN    = 6,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_i,
  input  logic              dm_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              eop_o,
  output logic              rx_active_o
);
  logic edge_s, eop_s, start_s, active_s, strobe_s, shift_s;

  usbrx_line u_line (
    .clk_i, .rst_ni, .dp_i, .dm_i,
    .edge_o(edge_s), .eop_o(eop_s), .start_o(start_s), .active_o(active_s)
  );

  usbrx_timer #(.OVERSAMPLE(OVERSAMPLE), .RESYNC_DELAY(RESYNC_DELAY)) u_timer (
    .clk_i, .rst_ni, .edge_i(edge_s), .strobe_o(strobe_s)
  );

  assign shift_s = strobe_s && active_s && !eop_s;

  usbrx_deser #(.DATA_W(DATA_W), .STUFF_LEN(STUFF_LEN)) u_deser (
    .clk_i, .rst_ni, .start_i(start_s), .eop_i(eop_s), .shift_i(shift_s),
    .dp_i, .data_o(rx_byte_o), .valid_o(rx_valid_o)
  );

  assign eop_o       = eop_s;
  assign rx_active_o = active_s;

  // R8
  eop_no_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !rx_valid_o);
endmodule

// File: tb/sim_usb_fs_rx.sv
`timescale 1ns/1ps
module sim_usb_fs_rx;
  logic       clk = 1'b0, rst_ni = 1'b0, dp = 1'b1, dm = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid, eop, rx_active;
  int         n_cmp = 0, n_bad = 0;
  logic [7:0] got[$];
  logic [7:0] pl[$];

  always #10 clk = ~clk;

  usb_fs_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dp_i(dp), .dm_i(dm),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .eop_o(eop), .rx_active_o(rx_active)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  logic m_last_dp = 1'b1, m_prev = 1'b1, m_active = 1'b0, m_valid = 1'b0;
  int   m_since = 0, m_ones = 0;
  bit   m_q[$];
  logic [7:0] m_byte = '0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_last_dp = 1'b1; m_prev = 1'b1; m_active = 1'b0; m_valid = 1'b0;
      m_since = 0; m_ones = 0; m_q.delete();
    end else begin
      bit se0, e, fire, b, st;
      se0 = !dp && !dm;
      e   = (dp != m_last_dp);
      fire = ((m_since % 8) == 2) && m_active && !se0;
      st  = e && m_last_dp && !se0 && !m_active;
      m_valid = 1'b0;
      if (fire) begin
        b = (dp == m_prev);
        m_prev = dp;
        if (m_ones == 6) m_ones = 0;
        else begin
          m_ones = b ? m_ones + 1 : 0;
          m_q.push_back(b);
          if (m_q.size() == 8) begin
            for (int i = 0; i < 8; i++) m_byte[i] = m_q[i];
            m_q.delete();
            m_valid = 1'b1;
          end
        end
      end
      if (se0) begin m_q.delete(); m_ones = 0; end
      if (st) begin m_prev = 1'b1; m_q.delete(); m_ones = 0; end
      if (se0) m_active = 1'b0;
      else if (st) m_active = 1'b1;
      m_since = e ? 0 : m_since + 1;
      m_last_dp = dp;
    end
    #5;
    if (rst_ni) begin
      chk("R5", "rx_valid_o", int'(rx_valid), int'(m_valid));
      if (m_valid) chk("R5", "rx_byte_o", int'(rx_byte), int'(m_byte));
      chk("R7", "eop_o", int'(eop), int'(!dp && !dm));
      chk("R2", "rx_active_o", int'(rx_active), int'(m_active));
      if (rx_valid) got.push_back(rx_byte);
    end
  end

  task automatic drive(input logic lvl, input int w);
    dp = lvl; dm = ~lvl;
    repeat (w) @(negedge clk);
  endtask

  task automatic se0(input int w);
    dp = 1'b0; dm = 1'b0;
    repeat (w) @(negedge clk);
  endtask

  task automatic send_pkt(input string tag, input bit jit, input int part_n, input logic [7:0] part_v);
    bit raw[$], tx[$];
    logic [7:0] exp_q[$];
    logic lvl = 1'b1;
    int ones = 0;
    exp_q.push_back(8'h80);
    for (int i = 0; i < 8; i++) raw.push_back(i == 7);
    foreach (pl[k]) begin
      exp_q.push_back(pl[k]);
      for (int i = 0; i < 8; i++) raw.push_back(pl[k][i]);
    end
    for (int i = 0; i < part_n; i++) raw.push_back(part_v[i]);
    foreach (raw[k]) begin
      tx.push_back(raw[k]);
      ones = raw[k] ? ones + 1 : 0;
      if (ones == 6) begin tx.push_back(1'b0); ones = 0; end
    end
    got.delete();
    foreach (tx[k]) begin
      if (!tx[k]) lvl = ~lvl;
      drive(lvl, jit ? ((k % 2 == 0) ? 9 : 7) : 8);
    end
    se0(16);
    drive(1'b1, 24);
    chk(tag, "byte count", got.size(), exp_q.size());
    foreach (exp_q[k])
      if (k < got.size()) chk(tag, "packet byte", int'(got[k]), int'(exp_q[k]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "rx_valid_o in reset", int'(rx_valid), 0);
    chk("R1", "rx_active_o in reset", int'(rx_active), 0);
    rst_ni = 1'b1;
    drive(1'b1, 12);
    pl = '{8'h2D, 8'h00, 8'h10};
    send_pkt("R4", 1'b0, 0, 8'h00);
    pl = '{8'hC3, 8'h5A, 8'h96, 8'hE7};
    send_pkt("R3", 1'b1, 0, 8'h00);
    pl = '{8'hFF, 8'h7E, 8'hFF, 8'h01, 8'hFC};
    send_pkt("R6", 1'b0, 0, 8'h00);
    pl = '{8'hFF, 8'h3F};
    send_pkt("R6", 1'b1, 0, 8'h00);
    pl = '{8'hA5};
    send_pkt("R8", 1'b0, 5, 8'h1F);
    // R9: SE0 then J alone must not open a packet
    got.delete();
    se0(10);
    drive(1'b1, 40);
    chk("R9", "rx_active_o after SE0->J", int'(rx_active), 0);
    chk("R9", "bytes after SE0->J", got.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule